// File: doc/BRIEF.md
# UART Modem Handshake and Loopback Unit

This unit sits next to a UART transmitter and receiver and owns the modem handshake lines and the internal loopback path. It drives an active-low request-to-send line. That line follows a software control bit, or, when automatic mode is on, the occupancy of the receive FIFO. It takes in an active-low clear-to-send line, resynchronizes it, reports it with a sticky change flag, and can stop the transmitter from starting new characters while the far end is not ready.

A loopback mode sends the transmitter's serial stream straight into the receiver. In that mode the outgoing serial pin is parked at the mark level, request-to-send is held inactive, and the external serial input is ignored. The receive FIFO level, the trigger threshold, the transmitter's character-boundary strobe and the status-read strobe arrive as plain inputs. Register access, baud timing, FIFOs and in-band flow control belong to neighbouring blocks.

Top module: `uart_modem_ctl`

## Requirements
- R1: While `rst_n` is low, `rts_n` is 1, `msr_cts` is 0, `msr_dcts` is 0 and `tx_allow` is 1.
- R2: With `auto_rts_en` low and `ctl_loop` low, `rts_n` equals the inverse of the `ctl_rts_on` value sampled at the previous rising clock edge.
- R3: With `auto_rts_en` high and `ctl_loop` low, `rts_n` is 1 one cycle after `rx_level >= rx_trig` (unsigned) and 0 one cycle after `rx_level < rx_trig`, whatever the value of `ctl_rts_on`.
- R4: `cts_n` passes through a chain of SYNC_STAGES flops and then one status flop. Outside loopback, `msr_cts` (1 = far end ready) equals the inverse of `cts_n` as sampled SYNC_STAGES+1 rising edges earlier.
- R5: `msr_dcts` is set on the edge that changes `msr_cts`. It stays set until an edge at which `status_rd` is high and `msr_cts` does not change, and it is then cleared. A change wins over a read in the same cycle.
- R6: With `auto_cts_en` low, `tx_allow` is 1.
- R7: With `auto_cts_en` high, `tx_allow` changes only at rising edges where `tx_boundary` is high. It then takes the ready value (1 = ready) that `msr_cts` would capture at that same edge.
- R8: With `ctl_loop` high, `tx_pin` is 1, `rts_n` is 1, `rx_serial_out` equals `tx_serial_in`, and `rx_pin` has no effect on any output. With `ctl_loop` low, `tx_pin` follows `tx_serial_in` and `rx_serial_out` follows `rx_pin`.
- R9: With `ctl_loop` high, the status path uses the internal request-to-send state (1 = asserted) in place of the synchronized `cts_n`, one edge later on `msr_cts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_rts_on | input | 1 | Software request-to-send: 1 asserts the line |
| ctl_loop | input | 1 | Internal loopback enable |
| auto_rts_en | input | 1 | Automatic request-to-send from FIFO level |
| auto_cts_en | input | 1 | Transmit gating by clear-to-send |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_trig | input | LVL_W | Receive FIFO threshold |
| status_rd | input | 1 | Strobe: status has been read, clears change flag |
| tx_boundary | input | 1 | Strobe: transmitter is between characters |
| tx_serial_in | input | 1 | Serial stream from the transmitter |
| rx_serial_out | output | 1 | Serial stream to the receiver |
| tx_pin | output | 1 | Outgoing serial pin |
| rx_pin | input | 1 | Incoming serial pin |
| rts_n | output | 1 | Request-to-send pin, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| msr_cts | output | 1 | Far end ready status |
| msr_dcts | output | 1 | Sticky change of ready status |
| tx_allow | output | 1 | Transmitter may start a new character |

## Verification
The bench builds the unit with SYNC_STAGES = 3 and LVL_W = 4. The deeper chain shows that status latency follows the parameter rather than a fixed two-flop delay. The narrow level width makes a random walk reach level 0, the full value 15 and the exact threshold crossing often. The reference model tracks the synchronizer as a queue of that length. This puts status reads that coincide with ready changes, and boundary strobes that coincide with clear-to-send edges, well within reach.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
   localparam logic MARK_LEVEL = 1'b1;
   typedef enum logic {RTS_SRC_SW = 1'b0, RTS_SRC_AUTO = 1'b1} rts_src_e;

   function automatic logic lvl_reached(input int unsigned lvl, input int unsigned trig);
      return lvl >= trig;
   endfunction
endpackage

// File: rtl/mdm_cts_sync.sv
module mdm_cts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_n,
   output logic q_n
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("mdm_cts_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d_n;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_n = chain[STAGES-1];
endmodule

// File: rtl/mdm_rts_ctl.sv
module mdm_rts_ctl
   import uart_modem_pkg::*;
#(
   parameter int LVL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_on,
   input  logic             auto_en,
   input  logic [LVL_W-1:0] lvl,
   input  logic [LVL_W-1:0] trig,
   output logic             rts_act
);
   rts_src_e src;
   logic     want;

   always_comb begin
      src  = auto_en ? RTS_SRC_AUTO : RTS_SRC_SW;
      want = (src == RTS_SRC_AUTO) ? !lvl_reached(int'(lvl), int'(trig)) : sw_on;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rts_act <= 1'b0;
      else        rts_act <= want;
   end
endmodule

// File: rtl/mdm_status.sv
module mdm_status (
   input  logic clk,
   input  logic rst_n,
   input  logic loop_en,
   input  logic rts_act,
   input  logic cts_sync_n,
   input  logic rd_strobe,
   output logic ready_now,
   output logic ready_q,
   output logic delta_q
);
   always_comb ready_now = loop_en ? rts_act : !cts_sync_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         delta_q <= 1'b0;
      end else begin
         ready_q <= ready_now;
         delta_q <= (ready_now != ready_q) | (delta_q & !rd_strobe);
      end
   end
endmodule

// File: rtl/mdm_tx_gate.sv
module mdm_tx_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_en,
   input  logic ready_now,
   input  logic boundary,
   output logic allow
);
   logic held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        held <= 1'b1;
      else if (boundary) held <= !gate_en | ready_now;
   end

   assign allow = !gate_en | held;
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
   import uart_modem_pkg::*;
#(
   parameter int LVL_W       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_rts_on,
   input  logic             ctl_loop,
   input  logic             auto_rts_en,
   input  logic             auto_cts_en,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] rx_trig,
   input  logic             status_rd,
   input  logic             tx_boundary,
   input  logic             tx_serial_in,
   output logic             rx_serial_out,
   output logic             tx_pin,
   input  logic             rx_pin,
   output logic             rts_n,
   input  logic             cts_n,
   output logic             msr_cts,
   output logic             msr_dcts,
   output logic             tx_allow
);
   generate
      if (LVL_W < 1 || LVL_W > 16) begin : g_bad_lvl
         $error("uart_modem_ctl: LVL_W out of range 1..16");
      end
   endgenerate

   logic rts_act;
   logic cts_sync_n;
   logic ready_now;

   mdm_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_n(cts_n), .q_n(cts_sync_n)
   );

   mdm_rts_ctl #(.LVL_W(LVL_W)) u_rts (
      .clk(clk), .rst_n(rst_n), .sw_on(ctl_rts_on), .auto_en(auto_rts_en),
      .lvl(rx_level), .trig(rx_trig), .rts_act(rts_act)
   );

   mdm_status u_stat (
      .clk(clk), .rst_n(rst_n), .loop_en(ctl_loop), .rts_act(rts_act),
      .cts_sync_n(cts_sync_n), .rd_strobe(status_rd), .ready_now(ready_now),
      .ready_q(msr_cts), .delta_q(msr_dcts)
   );

   mdm_tx_gate u_gate (
      .clk(clk), .rst_n(rst_n), .gate_en(auto_cts_en), .ready_now(ready_now),
      .boundary(tx_boundary), .allow(tx_allow)
   );

   always_comb begin
      if (ctl_loop) begin
         tx_pin        = MARK_LEVEL;
         rts_n         = 1'b1;
         rx_serial_out = tx_serial_in;
      end else begin
         tx_pin        = tx_serial_in;
         rts_n         = !rts_act;
         rx_serial_out = rx_pin;
      end
   end
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk #(
   parameter int LVL_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_rts_on,
   input logic             ctl_loop,
   input logic             auto_rts_en,
   input logic             auto_cts_en,
   input logic [LVL_W-1:0] rx_level,
   input logic [LVL_W-1:0] rx_trig,
   input logic             status_rd,
   input logic             tx_boundary,
   input logic             tx_serial_in,
   input logic             rx_serial_out,
   input logic             tx_pin,
   input logic             rts_n,
   input logic             msr_cts,
   input logic             msr_dcts,
   input logic             tx_allow
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R8
   loop_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_loop |-> (tx_pin && rts_n && (rx_serial_out == tx_serial_in)));

   // R2
   manual_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !ctl_loop && $past(!auto_rts_en)) |-> (rts_n == !$past(ctl_rts_on)));

   // R3
   auto_rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !ctl_loop && $past(auto_rts_en && (rx_level >= rx_trig))) |-> rts_n);

   // R5
   dcts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (msr_cts != $past(msr_cts))) |-> msr_dcts);

   // R5
   dcts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(msr_dcts) && !$past(status_rd)) |-> msr_dcts);

   // R6
   cts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_cts_en |-> tx_allow);

   // R7
   gate_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && auto_cts_en && $past(auto_cts_en) && !$past(tx_boundary))
         |-> (tx_allow == $past(tx_allow)));
endmodule

bind uart_modem_ctl uart_modem_ctl_chk #(.LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_rts_on(ctl_rts_on), .ctl_loop(ctl_loop),
   .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .rx_level(rx_level),
   .rx_trig(rx_trig), .status_rd(status_rd), .tx_boundary(tx_boundary),
   .tx_serial_in(tx_serial_in), .rx_serial_out(rx_serial_out), .tx_pin(tx_pin),
   .rts_n(rts_n), .msr_cts(msr_cts), .msr_dcts(msr_dcts), .tx_allow(tx_allow)
);

// File: tb/uart_modem_ctl_bench.sv
module uart_modem_ctl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LVL_W      = 4;
   localparam int SYNC       = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_rts_on = 0, ctl_loop = 0, auto_rts_en = 0, auto_cts_en = 0;
   logic [LVL_W-1:0] rx_level = '0, rx_trig = '0;
   logic status_rd = 0, tx_boundary = 0, tx_serial_in = 1, rx_pin = 1, cts_n = 1;
   logic rx_serial_out, tx_pin, rts_n, msr_cts, msr_dcts, tx_allow;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_modem_ctl #(.LVL_W(LVL_W), .SYNC_STAGES(SYNC)) u_uart_modem_ctl (
      .clk(clk), .rst_n(rst_n), .ctl_rts_on(ctl_rts_on), .ctl_loop(ctl_loop),
      .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .rx_level(rx_level),
      .rx_trig(rx_trig), .status_rd(status_rd), .tx_boundary(tx_boundary),
      .tx_serial_in(tx_serial_in), .rx_serial_out(rx_serial_out), .tx_pin(tx_pin),
      .rx_pin(rx_pin), .rts_n(rts_n), .cts_n(cts_n), .msr_cts(msr_cts),
      .msr_dcts(msr_dcts), .tx_allow(tx_allow)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   bit m_rts, m_msr, m_dcts, m_hold;
   bit pipe[$];

   task automatic check(input string req, input string what, input logic act, input bit exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      bit rep, n_rts;
      if (!rst_n) begin
         m_rts = 0; m_msr = 0; m_dcts = 0; m_hold = 1;
         pipe.delete();
         for (int i = 0; i < SYNC; i++) pipe.push_back(1'b1);
      end else begin
         rep    = ctl_loop ? m_rts : !pipe[SYNC-1];
         n_rts  = auto_rts_en ? (int'(rx_level) < int'(rx_trig)) : ctl_rts_on;
         m_dcts = (rep != m_msr) || (m_dcts && !status_rd);
         m_msr  = rep;
         if (tx_boundary) m_hold = !auto_cts_en || rep;
         m_rts  = n_rts;
         pipe.push_front(cts_n);
         void'(pipe.pop_back());
      end
      #(CLK_PERIOD/4);
      if (!rst_n) begin
         check("R1", "rts_n", rts_n, 1'b1);
         check("R1", "msr_cts", msr_cts, 1'b0);
         check("R1", "msr_dcts", msr_dcts, 1'b0);
         check("R1", "tx_allow", tx_allow, 1'b1);
      end else begin
         check(ctl_loop ? "R8" : (auto_rts_en ? "R3" : "R2"), "rts_n", rts_n,
               ctl_loop ? 1'b1 : !m_rts);
         check("R8", "tx_pin", tx_pin, ctl_loop ? 1'b1 : tx_serial_in);
         check("R8", "rx_serial_out", rx_serial_out, ctl_loop ? tx_serial_in : rx_pin);
         check(ctl_loop ? "R9" : "R4", "msr_cts", msr_cts, m_msr);
         check("R5", "msr_dcts", msr_dcts, m_dcts);
         check(auto_cts_en ? "R7" : "R6", "tx_allow", tx_allow, !auto_cts_en || m_hold);
      end
   end

   // one cycle of random stimulus, driven at the falling edge
   task automatic drive(input int p_cts, input int p_rd, input int p_bnd);
      @(negedge clk);
      if ($urandom_range(99) < 20) ctl_rts_on = !ctl_rts_on;
      if ($urandom_range(99) < p_cts) cts_n = !cts_n;
      status_rd   = ($urandom_range(99) < p_rd);
      tx_boundary = ($urandom_range(99) < p_bnd);
      tx_serial_in = $urandom_range(1);
      rx_pin       = $urandom_range(1);
      case ($urandom_range(2))
         0: if (rx_level != '0) rx_level = rx_level - 1'b1;
         1: if (rx_level != '1) rx_level = rx_level + 1'b1;
         default: ;
      endcase
   endtask

   task automatic phase(input bit lp, input bit ar, input bit ac, input int cycles);
      @(negedge clk);
      ctl_loop = lp; auto_rts_en = ar; auto_cts_en = ac;
      rx_trig = LVL_W'($urandom_range((1 << LVL_W) - 1));
      for (int i = 0; i < cycles; i++) drive(8, 15, 25);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2: manual request-to-send
      phase(0, 0, 0, 200);
      // R3: automatic request-to-send over level walk, including 0 and full
      rx_level = '0;
      phase(0, 1, 0, 300);
      rx_level = '1;
      phase(0, 1, 0, 200);
      // R4 R5 R6: status path with gating off
      phase(0, 0, 0, 200);
      // R7: gated transmitter
      phase(0, 0, 1, 400);
      phase(0, 1, 1, 300);
      // R8 R9: loopback
      phase(1, 0, 0, 300);
      phase(1, 1, 1, 300);
      // mixed modes, with mode changes mid-stream
      for (int k = 0; k < 16; k++)
         phase($urandom_range(1), $urandom_range(1), $urandom_range(1), 60);
      // R1: reset mid-run
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      phase(0, 0, 1, 100);
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule